// File: doc/BRIEF.md
# Configurable Memory Mat with Compare

This block is one storage tile of a reconfigurable on-chip memory. It holds 1024 entries of 64 data bits. Each entry also carries a valid flag and a 4-bit control field that higher layers may use as they see fit. Two request ports work side by side, and each can issue one operation per cycle. A response comes back one clock after the request, so the mat can serve two 64-bit accesses in every cycle.

Besides plain reads and writes, the mat offers three more operations. The first is an in-place read-modify-write on port 0. It returns the old word and writes back a combined value on the next cycle, using the port 1 write slot. The second is a compare-read: the masked stored data is checked against a supplied key, and the result is reported as a match flag on the read path. The third is a flash clear, which drops the valid flag and control field of every entry in a single cycle. A tag or lookup structure built on the mat uses compare-reads and flash clears, and it uses read-modify-write for counters and flag updates.

Top module: `cmat_top`

## Requirements
- R1: The opcode encoding on both ports is 0 idle, 1 read, 2 write, 3 read-modify-write, 4 compare-read, 5 flash clear, and 6 and 7 idle. A read, compare-read or port-0 read-modify-write issued in cycle t raises the port's response flag in cycle t+1, with the entry's data, valid flag and control field. In any other case the response flag is low.
- R2: A write stores the data, sets the entry's valid flag to 1 and stores the supplied control field. A read of that address in the next cycle returns the new values.
- R3: A read of an address that the other port writes in the same cycle returns the entry's prior contents.
- R4: When both ports write the same address in the same cycle, the port 0 data and control field are kept.
- R5: A flash clear from either port sets the valid flag and control field of every entry to 0 in one cycle. A read issued in the same cycle returns the pre-clear values. A write issued in the same cycle as the clear takes effect after the clear, so its entry stays valid.
- R6: The match flag is high only on a compare-read response whose entry is valid and whose stored data equals the key in every bit set in the mask. Bits where the mask is 0 are ignored. A read response never raises the match flag.
- R7: On port 0, a read-modify-write returns the old data as its response. It stores old AND operand, old OR operand, old XOR operand, or old plus operand modulo 2^64, for function codes 0, 1, 2 and 3. The valid flag and control field of the entry are left unchanged.
- R8: A read on either port, or a further read-modify-write, issued in the cycle after a read-modify-write of the same address sees the modified value. Back-to-back read-modify-writes of one address therefore accumulate.
- R9: The write-back of a read-modify-write occupies the port 1 write slot in the cycle after the request, and a port 1 write in that cycle is dropped. A port 0 write in that cycle to the same address wins over the write-back.
- R10: Opcode 3 on port 1 is ignored. It produces no response and changes no entry.
- R11: After reset both response flags are low and every entry reads as not valid with a zero control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_op | input | 3 | Port 0 opcode |
| p0_addr | input | 10 | Port 0 entry address |
| p0_wdata | input | 64 | Port 0 write data or modify operand |
| p0_wctrl | input | 4 | Port 0 control field to store on write |
| p0_fn | input | 2 | Port 0 modify function (AND, OR, XOR, ADD) |
| p0_key | input | 64 | Port 0 compare key |
| p0_mask | input | 64 | Port 0 compare mask, 1 = bit takes part |
| p0_rsp | output | 1 | Port 0 response present |
| p0_rdata | output | 64 | Port 0 read data |
| p0_vld | output | 1 | Port 0 entry valid flag |
| p0_ctrl | output | 4 | Port 0 entry control field |
| p0_match | output | 1 | Port 0 compare result |
| p1_op | input | 3 | Port 1 opcode |
| p1_addr | input | 10 | Port 1 entry address |
| p1_wdata | input | 64 | Port 1 write data |
| p1_wctrl | input | 4 | Port 1 control field to store on write |
| p1_key | input | 64 | Port 1 compare key |
| p1_mask | input | 64 | Port 1 compare mask |
| p1_rsp | output | 1 | Port 1 response present |
| p1_rdata | output | 64 | Port 1 read data |
| p1_vld | output | 1 | Port 1 entry valid flag |
| p1_ctrl | output | 4 | Port 1 entry control field |
| p1_match | output | 1 | Port 1 compare result |

## Verification
The assertions check several rules on every cycle. Response timing follows the opcode, port 1 ignores opcode 3, a match never appears without a valid entry or outside a compare-read, a write is read back in the next cycle, and an entry reads as invalid right after a clear. The bench scenarios cover the behaviour that needs known contents and exact sequences. These include the four modify functions with carry wrap-around, forwarding and accumulation across back-to-back modifies, the dropped port 1 write in the write-back slot, port-priority collisions, masked compare outcomes, and read-before-write during a clear.

// File: rtl/cmat_pkg.sv
package cmat_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_RMW   = 3'd3,
    OP_CMP   = 3'd4,
    OP_CLEAR = 3'd5
  } cmat_op_e;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_XOR = 2'd2,
    FN_ADD = 2'd3
  } cmat_fn_e;

endpackage

// File: rtl/cmat_data.sv
// Data storage: two write channels, two registered read channels.
// Channel 0 is written last, so it wins on an address collision.
module cmat_data #(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rq0,
  output logic [DW-1:0] rq1
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we1) store[wa1] <= wd1;
    if (we0) store[wa0] <= wd0;
    rq0 <= store[ra0];
    rq1 <= store[ra1];
  end

endmodule

// File: rtl/cmat_meta.sv
// Valid flag and control field per entry, kept in flops so a whole-array
// clear fits in one cycle. Writes in the clear cycle land after it.
module cmat_meta #(
  parameter int DEPTH = 1024,
  parameter int CW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int MW   = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [MW-1:0] wm0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [MW-1:0] wm1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [MW-1:0] rq0,
  output logic [MW-1:0] rq1
);

  logic [MW-1:0] tag [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) tag[i] <= '0;
    end
    if (!rst) begin
      if (we1) tag[wa1] <= wm1;
      if (we0) tag[wa0] <= wm0;
    end
    rq0 <= tag[ra0];
    rq1 <= tag[ra1];
  end

endmodule

// File: rtl/cmat_rmw.sv
// Holds a port-0 modify request for one cycle and forms the write-back
// value from the (already forwarded) old data seen on the port 0 read path.
module cmat_rmw
  import cmat_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] opnd,
  input  logic [1:0]    fn,
  input  logic [DW-1:0] old_data,
  output logic          pend_v,
  output logic [AW-1:0] pend_a,
  output logic [DW-1:0] pend_d
);

  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opnd_q;
  logic [1:0]    fn_q;
  logic [DW-1:0] result;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= issue;
    addr_q <= addr;
    opnd_q <= opnd;
    fn_q   <= fn;
  end

  always_comb begin
    case (cmat_fn_e'(fn_q))
      FN_AND:  result = old_data & opnd_q;
      FN_OR:   result = old_data | opnd_q;
      FN_XOR:  result = old_data ^ opnd_q;
      default: result = old_data + opnd_q;
    endcase
  end

  assign pend_v = busy_q;
  assign pend_a = addr_q;
  assign pend_d = result;

endmodule

// File: rtl/cmat_rdpath.sv
// One read port's output stage: response timing, forwarding of a pending
// modify write-back, and the masked compare on the read data.
module cmat_rdpath #(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  parameter int CW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int MW   = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          cmp_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] key,
  input  logic [DW-1:0] mask,
  input  logic          pend_v,
  input  logic [AW-1:0] pend_a,
  input  logic [DW-1:0] pend_d,
  input  logic [DW-1:0] mem_q,
  input  logic [MW-1:0] meta_q,
  output logic          rsp,
  output logic [DW-1:0] rdata,
  output logic          vbit,
  output logic [CW-1:0] ctrl,
  output logic          match
);

  logic          rsp_q;
  logic          cmp_q;
  logic          hit_q;
  logic [DW-1:0] fwd_q;
  logic [DW-1:0] key_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= 1'b0;
      cmp_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      rsp_q <= rd_en;
      cmp_q <= rd_en && cmp_en;
      hit_q <= pend_v && (pend_a == addr);
    end
    fwd_q  <= pend_d;
    key_q  <= key;
    mask_q <= mask;
  end

  assign rdata = hit_q ? fwd_q : mem_q;
  assign vbit  = meta_q[CW];
  assign ctrl  = meta_q[CW-1:0];
  assign diff  = (rdata ^ key_q) & mask_q;
  assign rsp   = rsp_q;
  assign match = rsp_q && cmp_q && vbit && (diff == '0);

endmodule

// File: rtl/cmat_top.sv
module cmat_top
  import cmat_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  parameter int CW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    p0_op,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  input  logic [CW-1:0] p0_wctrl,
  input  logic [1:0]    p0_fn,
  input  logic [DW-1:0] p0_key,
  input  logic [DW-1:0] p0_mask,
  output logic          p0_rsp,
  output logic [DW-1:0] p0_rdata,
  output logic          p0_vld,
  output logic [CW-1:0] p0_ctrl,
  output logic          p0_match,
  input  logic [2:0]    p1_op,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  input  logic [CW-1:0] p1_wctrl,
  input  logic [DW-1:0] p1_key,
  input  logic [DW-1:0] p1_mask,
  output logic          p1_rsp,
  output logic [DW-1:0] p1_rdata,
  output logic          p1_vld,
  output logic [CW-1:0] p1_ctrl,
  output logic          p1_match
);

  localparam int NP = 2;
  localparam int MW = CW + 1;

  logic [2:0]    op_a    [NP];
  logic [AW-1:0] addr_a  [NP];
  logic [DW-1:0] key_a   [NP];
  logic [DW-1:0] mask_a  [NP];
  logic          rd_en   [NP];
  logic          cmp_en  [NP];
  logic          wr_en   [NP];
  logic          clr_en  [NP];
  logic [DW-1:0] mem_q   [NP];
  logic [MW-1:0] meta_q  [NP];
  logic          rsp_a   [NP];
  logic [DW-1:0] rdata_a [NP];
  logic          vbit_a  [NP];
  logic [CW-1:0] ctrl_a  [NP];
  logic          match_a [NP];

  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d;
  logic          clr_any;
  logic          d_we1;
  logic [AW-1:0] d_wa1;
  logic [DW-1:0] d_wd1;
  logic          m_we1;

  assign op_a[0]   = p0_op;
  assign op_a[1]   = p1_op;
  assign addr_a[0] = p0_addr;
  assign addr_a[1] = p1_addr;
  assign key_a[0]  = p0_key;
  assign key_a[1]  = p1_key;
  assign mask_a[0] = p0_mask;
  assign mask_a[1] = p1_mask;

  // Opcode decode and read path, one copy per port. Only port 0 may modify.
  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam bit MOD_OK = (p == 0);
    assign cmp_en[p] = (op_a[p] == OP_CMP);
    assign wr_en[p]  = (op_a[p] == OP_WRITE);
    assign clr_en[p] = (op_a[p] == OP_CLEAR);
    assign rd_en[p]  = (op_a[p] == OP_READ) || cmp_en[p] ||
                       (MOD_OK && (op_a[p] == OP_RMW));

    cmat_rdpath #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rd (
      .clk    (clk),
      .rst    (rst),
      .rd_en  (rd_en[p]),
      .cmp_en (cmp_en[p]),
      .addr   (addr_a[p]),
      .key    (key_a[p]),
      .mask   (mask_a[p]),
      .pend_v (pend_v),
      .pend_a (pend_a),
      .pend_d (pend_d),
      .mem_q  (mem_q[p]),
      .meta_q (meta_q[p]),
      .rsp    (rsp_a[p]),
      .rdata  (rdata_a[p]),
      .vbit   (vbit_a[p]),
      .ctrl   (ctrl_a[p]),
      .match  (match_a[p])
    );
  end

  assign clr_any = clr_en[0] || clr_en[1];

  // The modify write-back owns write channel 1 in its cycle; the port 1
  // write is then dropped, and it never touches the metadata.
  assign d_we1 = pend_v || wr_en[1];
  assign d_wa1 = pend_v ? pend_a : p1_addr;
  assign d_wd1 = pend_v ? pend_d : p1_wdata;
  assign m_we1 = !pend_v && wr_en[1];

  cmat_rmw #(.DEPTH(DEPTH), .DW(DW)) u_rmw (
    .clk      (clk),
    .rst      (rst),
    .issue    (p0_op == OP_RMW),
    .addr     (p0_addr),
    .opnd     (p0_wdata),
    .fn       (p0_fn),
    .old_data (rdata_a[0]),
    .pend_v   (pend_v),
    .pend_a   (pend_a),
    .pend_d   (pend_d)
  );

  cmat_data #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk (clk),
    .we0 (wr_en[0]),
    .wa0 (p0_addr),
    .wd0 (p0_wdata),
    .we1 (d_we1),
    .wa1 (d_wa1),
    .wd1 (d_wd1),
    .ra0 (p0_addr),
    .ra1 (p1_addr),
    .rq0 (mem_q[0]),
    .rq1 (mem_q[1])
  );

  cmat_meta #(.DEPTH(DEPTH), .CW(CW)) u_meta (
    .clk (clk),
    .rst (rst),
    .clr (clr_any),
    .we0 (wr_en[0]),
    .wa0 (p0_addr),
    .wm0 ({1'b1, p0_wctrl}),
    .we1 (m_we1),
    .wa1 (p1_addr),
    .wm1 ({1'b1, p1_wctrl}),
    .ra0 (p0_addr),
    .ra1 (p1_addr),
    .rq0 (meta_q[0]),
    .rq1 (meta_q[1])
  );

  assign p0_rsp   = rsp_a[0];
  assign p0_rdata = rdata_a[0];
  assign p0_vld   = vbit_a[0];
  assign p0_ctrl  = ctrl_a[0];
  assign p0_match = match_a[0];
  assign p1_rsp   = rsp_a[1];
  assign p1_rdata = rdata_a[1];
  assign p1_vld   = vbit_a[1];
  assign p1_ctrl  = ctrl_a[1];
  assign p1_match = match_a[1];

endmodule

// File: rtl/cmat_checker.sv
module cmat_checker
  import cmat_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 64,
  parameter int CW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    p0_op,
  input logic [AW-1:0] p0_addr,
  input logic [DW-1:0] p0_wdata,
  input logic [CW-1:0] p0_wctrl,
  input logic [1:0]    p0_fn,
  input logic [DW-1:0] p0_key,
  input logic [DW-1:0] p0_mask,
  input logic          p0_rsp,
  input logic [DW-1:0] p0_rdata,
  input logic          p0_vld,
  input logic [CW-1:0] p0_ctrl,
  input logic          p0_match,
  input logic [2:0]    p1_op,
  input logic [AW-1:0] p1_addr,
  input logic [DW-1:0] p1_wdata,
  input logic [CW-1:0] p1_wctrl,
  input logic [DW-1:0] p1_key,
  input logic [DW-1:0] p1_mask,
  input logic          p1_rsp,
  input logic [DW-1:0] p1_rdata,
  input logic          p1_vld,
  input logic [CW-1:0] p1_ctrl,
  input logic          p1_match
);

  AST_P0_RSP_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (p0_op == OP_READ || p0_op == OP_CMP || p0_op == OP_RMW) |=> p0_rsp); // R1

  AST_P0_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(p0_op == OP_READ || p0_op == OP_CMP || p0_op == OP_RMW) |=> !p0_rsp); // R1

  AST_P1_RSP_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (p1_op == OP_READ || p1_op == OP_CMP) |=> p1_rsp); // R1

  AST_P1_MODIFY_SILENT: assert property (@(posedge clk) disable iff (rst)
    (p1_op == OP_RMW) |=> !p1_rsp); // R10

  AST_P0_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    p0_match |-> p0_vld); // R6

  AST_P1_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    p1_match |-> p1_vld); // R6

  AST_P0_MATCH_ONLY_CMP: assert property (@(posedge clk) disable iff (rst)
    p0_match |-> $past(p0_op == OP_CMP)); // R6

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (p0_op == OP_WRITE) ##1 (p0_op == OP_READ && p0_addr == $past(p0_addr))
    |=> (p0_vld && p0_ctrl == $past(p0_wctrl, 2) && p0_rdata == $past(p0_wdata, 2))); // R2

  AST_CLEAR_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    (p0_op == OP_CLEAR && p1_op != OP_WRITE) ##1 (p0_op == OP_READ)
    |=> (!p0_vld && p0_ctrl == '0)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!p0_rsp && !p1_rsp)); // R11

endmodule

bind cmat_top cmat_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/cmat_top_bench.sv
module cmat_top_bench;
  import cmat_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  p0_op = '0;
  logic [9:0]  p0_addr = '0;
  logic [63:0] p0_wdata = '0;
  logic [3:0]  p0_wctrl = '0;
  logic [1:0]  p0_fn = '0;
  logic [63:0] p0_key = '0;
  logic [63:0] p0_mask = '0;
  logic        p0_rsp;
  logic [63:0] p0_rdata;
  logic        p0_vld;
  logic [3:0]  p0_ctrl;
  logic        p0_match;
  logic [2:0]  p1_op = '0;
  logic [9:0]  p1_addr = '0;
  logic [63:0] p1_wdata = '0;
  logic [3:0]  p1_wctrl = '0;
  logic [63:0] p1_key = '0;
  logic [63:0] p1_mask = '0;
  logic        p1_rsp;
  logic [63:0] p1_rdata;
  logic        p1_vld;
  logic [3:0]  p1_ctrl;
  logic        p1_match;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmat_top u_cmat_top (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drv0(input logic [2:0] op, input logic [9:0] a,
                      input logic [63:0] wd = '0, input logic [3:0] wc = '0,
                      input logic [1:0] fn = '0, input logic [63:0] key = '0,
                      input logic [63:0] mask = '0);
    p0_op = op; p0_addr = a; p0_wdata = wd; p0_wctrl = wc;
    p0_fn = fn; p0_key = key; p0_mask = mask;
  endtask

  task automatic drv1(input logic [2:0] op, input logic [9:0] a,
                      input logic [63:0] wd = '0, input logic [3:0] wc = '0,
                      input logic [63:0] key = '0, input logic [63:0] mask = '0);
    p1_op = op; p1_addr = a; p1_wdata = wd; p1_wctrl = wc;
    p1_key = key; p1_mask = mask;
  endtask

  // Present the driven requests for one edge, then settle away from it.
  task automatic tick();
    @(posedge clk);
    #1;
    p0_op = OP_IDLE;
    p1_op = OP_IDLE;
  endtask

  task automatic t_reset();
    chk("R11", "p0 rsp after reset", 64'(p0_rsp), 64'd0);
    chk("R11", "p1 rsp after reset", 64'(p1_rsp), 64'd0);
    drv0(OP_READ, 10'd5); drv1(OP_READ, 10'd1023); tick();
    chk("R11", "p0 valid after reset", 64'(p0_vld), 64'd0);
    chk("R11", "p1 ctrl after reset", 64'(p1_ctrl), 64'd0);
  endtask

  task automatic t_write_read();
    drv0(OP_WRITE, 10'd10, 64'hA5A5_0000_1234_5678, 4'h9);
    drv1(OP_WRITE, 10'd1023, 64'h0BAD_F00D_0000_0001, 4'h3); tick();
    chk("R1", "no rsp on write", 64'(p0_rsp), 64'd0);
    drv0(OP_READ, 10'd10); drv1(OP_READ, 10'd1023); tick();
    chk("R1", "p0 rsp on read", 64'(p0_rsp), 64'd1);
    chk("R2", "p0 data", p0_rdata, 64'hA5A5_0000_1234_5678);
    chk("R2", "p0 valid", 64'(p0_vld), 64'd1);
    chk("R2", "p0 ctrl", 64'(p0_ctrl), 64'h9);
    chk("R2", "p1 data top entry", p1_rdata, 64'h0BAD_F00D_0000_0001);
    chk("R2", "p1 ctrl top entry", 64'(p1_ctrl), 64'h3);
    drv0(7, 10'd10); tick();
    chk("R1", "opcode 7 idle", 64'(p0_rsp), 64'd0);
  endtask

  task automatic t_read_before_write();
    drv0(OP_WRITE, 10'd20, 64'hC0C0_C0C0, 4'h1); tick();
    drv0(OP_WRITE, 10'd20, 64'hB0B0_B0B0, 4'h2); drv1(OP_READ, 10'd20); tick();
    chk("R3", "same-cycle read old data", p1_rdata, 64'hC0C0_C0C0);
    chk("R3", "same-cycle read old ctrl", 64'(p1_ctrl), 64'h1);
    drv1(OP_READ, 10'd20); tick();
    chk("R3", "later read new data", p1_rdata, 64'hB0B0_B0B0);
  endtask

  task automatic t_collide();
    drv0(OP_WRITE, 10'd30, 64'hDDDD, 4'h1); drv1(OP_WRITE, 10'd30, 64'hEEEE, 4'h2); tick();
    drv0(OP_READ, 10'd30); tick();
    chk("R4", "port 0 data wins", p0_rdata, 64'hDDDD);
    chk("R4", "port 0 ctrl wins", 64'(p0_ctrl), 64'h1);
  endtask

  task automatic t_compare();
    logic [63:0] f = 64'hFACE_0000_CAFE_0042;
    drv0(OP_WRITE, 10'd40, f, 4'h3); tick();
    drv0(OP_CMP, 10'd40, '0, '0, '0, f, '1); tick();
    chk("R6", "full mask equal", 64'(p0_match), 64'd1);
    chk("R6", "compare rsp", 64'(p0_rsp), 64'd1);
    drv1(OP_CMP, 10'd40, '0, '0, f ^ 64'h1, '1); tick();
    chk("R6", "masked bit differs", 64'(p1_match), 64'd0);
    drv1(OP_CMP, 10'd40, '0, '0, f ^ 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF); tick();
    chk("R6", "unmasked bit ignored", 64'(p1_match), 64'd1);
    drv0(OP_READ, 10'd40, '0, '0, '0, f, '1); tick();
    chk("R6", "read never matches", 64'(p0_match), 64'd0);
    drv0(OP_CMP, 10'd41, '0, '0, '0, 64'd0, '1); tick();
    chk("R6", "invalid entry no match", 64'(p0_match), 64'd0);
  endtask

  task automatic t_modify();
    logic [63:0] x, y, e;
    for (int k = 0; k < 4; k++) begin
      x = (k == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hF0F0_1234_00FF_AAAA;
      y = (k == 3) ? 64'd2 : 64'h0FF0_4321_FF00_5555;
      case (k)
        0: e = x & y;
        1: e = x | y;
        2: e = x ^ y;
        default: e = x + y;
      endcase
      drv0(OP_WRITE, 10'(50 + k), x, 4'h6); tick();
      drv0(OP_RMW, 10'(50 + k), y, '0, 2'(k)); tick();
      chk("R7", $sformatf("fn %0d returns old", k), p0_rdata, x);
      tick();
      drv0(OP_READ, 10'(50 + k)); tick();
      chk("R7", $sformatf("fn %0d stored result", k), p0_rdata, e);
      chk("R7", $sformatf("fn %0d ctrl kept", k), 64'(p0_ctrl), 64'h6);
      chk("R7", $sformatf("fn %0d valid kept", k), 64'(p0_vld), 64'd1);
    end
  endtask

  task automatic t_forward();
    drv0(OP_WRITE, 10'd60, 64'h1111_2222, 4'h0); tick();
    drv0(OP_RMW, 10'd60, 64'hFFFF_0000, '0, FN_XOR); tick();
    drv1(OP_READ, 10'd60); tick();
    chk("R8", "port 1 sees modified", p1_rdata, 64'h1111_2222 ^ 64'hFFFF_0000);
    drv0(OP_WRITE, 10'd61, 64'd100, 4'h0); tick();
    drv0(OP_RMW, 10'd61, 64'd1, '0, FN_ADD); tick();
    drv0(OP_RMW, 10'd61, 64'd1, '0, FN_ADD); tick();
    chk("R8", "second modify sees first", p0_rdata, 64'd101);
    tick();
    drv0(OP_READ, 10'd61); tick();
    chk("R8", "modifies accumulate", p0_rdata, 64'd102);
  endtask

  task automatic t_slot();
    drv0(OP_WRITE, 10'd70, 64'h7070, 4'h2); tick();
    drv0(OP_RMW, 10'd71, 64'h1, '0, FN_OR); tick();
    drv1(OP_WRITE, 10'd70, 64'h9999, 4'h7); tick();
    drv0(OP_READ, 10'd70); tick();
    chk("R9", "port 1 write dropped data", p0_rdata, 64'h7070);
    chk("R9", "port 1 write dropped ctrl", 64'(p0_ctrl), 64'h2);
    drv0(OP_WRITE, 10'd72, 64'h5, 4'h1); tick();
    drv0(OP_RMW, 10'd72, 64'h3, '0, FN_ADD); tick();
    drv0(OP_WRITE, 10'd72, 64'hABCD, 4'h4); tick();
    drv0(OP_READ, 10'd72); tick();
    chk("R9", "port 0 write beats write-back", p0_rdata, 64'hABCD);
  endtask

  task automatic t_p1_modify();
    drv0(OP_WRITE, 10'd80, 64'h8080, 4'h5); tick();
    drv1(OP_RMW, 10'd80, 64'hFFFF); tick();
    chk("R10", "no rsp for port 1 modify", 64'(p1_rsp), 64'd0);
    tick();
    drv1(OP_READ, 10'd80); tick();
    chk("R10", "entry unchanged", p1_rdata, 64'h8080);
  endtask

  task automatic t_clear();
    drv0(OP_CLEAR, 10'd0); drv1(OP_READ, 10'd10); tick();
    chk("R5", "same-cycle read pre-clear valid", 64'(p1_vld), 64'd1);
    chk("R5", "same-cycle read pre-clear ctrl", 64'(p1_ctrl), 64'h9);
    drv0(OP_READ, 10'd10); drv1(OP_READ, 10'd1023); tick();
    chk("R5", "p0 valid after clear", 64'(p0_vld), 64'd0);
    chk("R5", "p0 ctrl after clear", 64'(p0_ctrl), 64'd0);
    chk("R5", "top entry valid after clear", 64'(p1_vld), 64'd0);
    drv0(OP_CMP, 10'd40, '0, '0, '0, 64'hFACE_0000_CAFE_0042, '1); tick();
    chk("R6", "cleared entry no match", 64'(p0_match), 64'd0);
    drv1(OP_CLEAR, 10'd0); drv0(OP_WRITE, 10'd90, 64'h9090, 4'h5); tick();
    drv0(OP_READ, 10'd90); tick();
    chk("R5", "write in clear cycle valid", 64'(p0_vld), 64'd1);
    chk("R5", "write in clear cycle ctrl", 64'(p0_ctrl), 64'h5);
    chk("R5", "write in clear cycle data", p0_rdata, 64'h9090);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_write_read();
    t_read_before_write();
    t_collide();
    t_compare();
    t_modify();
    t_forward();
    t_slot();
    t_p1_modify();
    t_clear();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

endmodule